// File: doc/BRIEF.md
# Endian-Selectable Read Bus Matcher

This block connects the read side of a FIFO that stores 36-bit long words to an output bus that may be 36, 18 or 9 bits wide. It takes one long word from the FIFO with a single pop. It then presents that word through one, two or four reads of the output bus. Whatever has not yet been presented waits in an auxiliary register. Each output value lands in a registered output one clock after the read that asks for it.

The bus width is set by two select lines, and the piece order by an endian select. All three are captured while the synchronous reset is high and stay fixed until the next reset. A byte is 9 bits, a word is two bytes, and a long word is four bytes. In big-endian order the most significant piece comes out first. In little-endian order the least significant piece comes out first. The FIFO shows its head word combinationally while it is not empty, and the pop output consumes that word.

Top module: `busmatch_rd`

## Requirements
- R1: While `rst` is high, `fifo_pop` stays low whatever `rd_en` is. After reset, `dout` reads zero and the next read starts a fresh long word.
- R2: In long mode (`bm_sel`=0), each read with the FIFO not empty pops one word. `dout` equals that full 36-bit word one clock after the read.
- R3: In word mode (`bm_sel`=1, `size_sel`=0), each long word takes two reads. The 18-bit pieces appear on `dout[17:0]`: bits 35:18 and 17:0 of the long word.
- R4: In byte mode (`bm_sel`=1, `size_sel`=1), each long word takes four reads. The 9-bit pieces appear on `dout[8:0]`: byte n is bits 9n+8:9n of the long word.
- R5: With `be_sel`=1 captured at reset, pieces come out from most significant to least significant. With `be_sel`=0 they come out from least significant to most significant.
- R6: In long mode, the captured endian setting has no effect on `dout`.
- R7: `fifo_pop` is asserted only for a read at the first piece of a long word while the FIFO is not empty. Reads of later pieces never pop the FIFO.
- R8: A cycle with `rd_en` low leaves `dout` and the piece position unchanged. The next read continues with the following piece.
- R9: A read at the first piece while `fifo_empty` is high does not pop the FIFO and leaves `dout` unchanged.
- R10: Changes on `be_sel`, `bm_sel` and `size_sel` after reset have no effect until the next reset.
- R11: In word and byte modes, the `dout` lines above the active piece are driven zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| bm_sel | input | 1 | 0 selects the 36-bit bus; 1 selects a narrow bus |
| size_sel | input | 1 | For a narrow bus: 0 gives 18 bits, 1 gives 9 bits |
| be_sel | input | 1 | 1 selects big-endian piece order, 0 little-endian |
| rd_en | input | 1 | Output bus read request |
| fifo_word | input | 36 | Head word shown by the FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word of the FIFO |
| dout | output | 36 | Output register |

## Verification
The assertions assume that the FIFO keeps its head word steady until it is popped. They also assume that `fifo_empty` tells the truth about whether a word is present, and that `rst` is high at time zero. The bench models the FIFO as an array indexed by a pointer. The pointer advances only on `fifo_pop`, and the empty flag is derived from that same pointer, so the FIFO word and the empty flag always agree. The bench drives all configuration lines steady during reset, then deliberately toggles them during operation to show that they are ignored.

// File: rtl/busmatch_pkg.sv
package busmatch_pkg;

    // Number of byte lanes in one long word; the piece orderings rely on four.
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        BW_LONG = 2'd0,
        BW_WORD = 2'd1,
        BW_BYTE = 2'd2
    } bus_width_e;

    typedef struct packed {
        bus_width_e width;
        logic       big;
    } bm_cfg_t;

    function automatic bus_width_e decode_width(input logic narrow, input logic bytewise);
        if (!narrow)
            return BW_LONG;
        else if (bytewise)
            return BW_BYTE;
        else
            return BW_WORD;
    endfunction

    // Index of the final piece of a long word for a given width.
    function automatic logic [1:0] final_piece(input bus_width_e w);
        case (w)
            BW_WORD: return 2'd1;
            BW_BYTE: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/busmatch_cfg_latch.sv
module busmatch_cfg_latch
    import busmatch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bm_sel,
    input  logic    size_sel,
    input  logic    be_sel,
    output bm_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.width <= decode_width(bm_sel, size_sel);
            cfg_q.big   <= be_sel;
        end
    end
endmodule

// File: rtl/busmatch_piece_ctr.sv
module busmatch_piece_ctr #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (adv)
            idx <= (idx == last) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/busmatch_lane_mux.sv
module busmatch_lane_mux
    import busmatch_pkg::*;
#(
    parameter int BYTE_W = 9,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic [WORD_W-1:0] src,
    input  bm_cfg_t           cfg,
    input  logic [1:0]        idx,
    output logic [WORD_W-1:0] piece
);
    localparam int HALF_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lane [LANES];
    logic [HALF_W-1:0] half [2];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = src[g*BYTE_W +: BYTE_W];
    end
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half[h] = src[h*HALF_W +: HALF_W];
    end

    logic [1:0] byte_sel;
    logic       half_sel;

    always_comb begin
        byte_sel = cfg.big ? (2'd3 - idx) : idx;
        half_sel = cfg.big ? ~idx[0] : idx[0];
        piece    = '0;
        case (cfg.width)
            BW_WORD: piece[HALF_W-1:0] = half[half_sel];
            BW_BYTE: piece[BYTE_W-1:0] = lane[byte_sel];
            default: piece             = src;
        endcase
    end
endmodule

// File: rtl/busmatch_rd.sv
module busmatch_rd
    import busmatch_pkg::*;
#(
    parameter int BYTE_W = 9,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bm_sel,
    input  logic              size_sel,
    input  logic              be_sel,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic [WORD_W-1:0] dout
);
    bm_cfg_t           cfg_q;
    logic [1:0]        piece_idx;
    logic [WORD_W-1:0] aux_q;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] piece;
    logic              at_start;
    logic              take;

    busmatch_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .bm_sel   (bm_sel),
        .size_sel (size_sel),
        .be_sel   (be_sel),
        .cfg_q    (cfg_q)
    );

    assign at_start = (piece_idx == 2'd0);
    assign fifo_pop = rd_en && !rst && at_start && !fifo_empty;
    assign take     = rd_en && !rst && (!at_start || !fifo_empty);
    assign src      = at_start ? fifo_word : aux_q;

    busmatch_piece_ctr #(.IDX_W(2)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .adv  (take),
        .last (final_piece(cfg_q.width)),
        .idx  (piece_idx)
    );

    busmatch_lane_mux #(.BYTE_W(BYTE_W)) u_mux (
        .src   (src),
        .cfg   (cfg_q),
        .idx   (piece_idx),
        .piece (piece)
    );

    always_ff @(posedge clk) begin
        if (rst)
            aux_q <= '0;
        else if (fifo_pop)
            aux_q <= fifo_word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (take)
            dout <= piece;
    end
endmodule

// File: rtl/busmatch_rd_chk.sv
module busmatch_rd_chk
    import busmatch_pkg::*;
#(
    parameter int BYTE_W = 9,
    localparam int WORD_W = BYTE_W * LANES
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [WORD_W-1:0] fifo_word,
    input logic              fifo_empty,
    input logic              fifo_pop,
    input logic [WORD_W-1:0] dout,
    input logic [1:0]        piece_idx,
    input bm_cfg_t           cfg
);
    // R1: no pop while in reset
    a_r1_no_pop_in_reset: assert property (@(posedge clk)
        rst |-> !fifo_pop);

    // R2: long mode loads the popped word whole
    a_r2_long_load: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && cfg.width == BW_LONG) |=> (dout == $past(fifo_word)));

    // R7: in narrow modes a pop is never followed directly by another pop
    a_r7_no_back_to_back_pop: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && cfg.width != BW_LONG) |=> !fifo_pop);

    // R8: idle cycles hold the output
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(dout));

    // R9: read of an empty FIFO at word start holds the output
    a_r9_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fifo_empty && piece_idx == 2'd0) |=> $stable(dout));

    // R11: unused upper lines stay zero in narrow modes
    a_r11_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg.width == BW_BYTE) |-> (dout[WORD_W-1:BYTE_W] == '0));

    a_r11_word_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg.width == BW_WORD) |-> (dout[WORD_W-1:2*BYTE_W] == '0));

    // R10: configuration holds once reset is released
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg));
endmodule

bind busmatch_rd busmatch_rd_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .fifo_word  (fifo_word),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .dout       (dout),
    .piece_idx  (piece_idx),
    .cfg        (cfg_q)
);

// File: tb/test_busmatch_rd.sv
`timescale 1ns/1ps
module test_busmatch_rd;
    localparam int NW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bm_sel = 1'b0;
    logic        size_sel = 1'b0;
    logic        be_sel = 1'b0;
    logic        rd_en = 1'b0;
    logic [35:0] fifo_word;
    logic        fifo_empty;
    logic        fifo_pop;
    logic [35:0] dout;
    logic        tb_clr = 1'b1;
    int          ptr;
    int          cid = 0;
    int          n_total = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [35:0] gen(input int c, input int k);
        logic [35:0] r;
        for (int j = 0; j < 4; j++)
            r[j*9 +: 9] = 9'((k*4 + j)*19 + c*7 + 3 + j*64);
        return r;
    endfunction

    function automatic logic [35:0] expect_piece(input int c, input int k, input int p,
                                                 input int mode, input bit big);
        int np, w, i;
        logic [63:0] full, mask;
        np   = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        w    = 36 / np;
        i    = big ? (np - 1 - p) : p;
        full = 64'(gen(c, k));
        mask = (64'd1 << w) - 64'd1;
        return 36'((full >> (i*w)) & mask);
    endfunction

    assign fifo_word  = (ptr < NW) ? gen(cid, ptr) : '0;
    assign fifo_empty = (ptr >= NW);

    always_ff @(posedge clk) begin
        if (tb_clr)
            ptr <= 0;
        else if (fifo_pop)
            ptr <= ptr + 1;
    end

    busmatch_rd i_busmatch_rd (
        .clk        (clk),
        .rst        (rst),
        .bm_sel     (bm_sel),
        .size_sel   (size_sel),
        .be_sel     (be_sel),
        .rd_en      (rd_en),
        .fifo_word  (fifo_word),
        .fifo_empty (fifo_empty),
        .fifo_pop   (fifo_pop),
        .dout       (dout)
    );

    task automatic check(input bit ok, input string tag, input logic [35:0] act,
                         input logic [35:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cfg=%0d actual=%h expected=%h", tag, cid, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        for (int c = 0; c < 6; c++) begin
            int  mode;
            bit  big;
            int  np;
            logic [35:0] last;
            mode = c / 2;
            big  = (c % 2) == 1;
            np   = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
            @(negedge clk);
            cid      = c;
            tb_clr   = 1'b1;
            rst      = 1'b1;
            bm_sel   = (mode != 0);
            size_sel = (mode == 2);
            be_sel   = big;
            rd_en    = 1'b1;
            @(posedge clk);
            @(negedge clk);
            // R1: reset blocks the pop
            check(fifo_pop == 1'b0, "R1 pop in reset", 36'(fifo_pop), 36'd0);
            @(posedge clk);
            @(negedge clk);
            rst    = 1'b0;
            tb_clr = 1'b0;
            rd_en  = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(dout == '0, "R1 dout after reset", dout, '0);
            // R10: disturb configuration lines after reset
            be_sel   = ~big;
            bm_sel   = (mode == 0);
            size_sel = (mode != 2);
            last = '0;
            for (int k = 0; k < NW; k++) begin
                for (int p = 0; p < np; p++) begin
                    logic [35:0] exp;
                    exp   = expect_piece(c, k, p, mode, big);
                    rd_en = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    rd_en = 1'b0;
                    if (mode == 0)
                        check(dout == exp, "R2 R6 R10 long word", dout, exp);
                    else if (mode == 1)
                        check(dout == exp, "R3 R5 R10 R11 word piece", dout, exp);
                    else
                        check(dout == exp, "R4 R5 R10 R11 byte piece", dout, exp);
                    check(ptr == k + 1, "R7 pop count", 36'(ptr), 36'(k + 1));
                    last = exp;
                    if ((k % 2) == 0 && p == 0) begin
                        @(posedge clk);
                        @(negedge clk);
                        check(dout == exp, "R8 idle hold", dout, exp);
                        check(ptr == k + 1, "R8 idle no pop", 36'(ptr), 36'(k + 1));
                    end
                end
            end
            rd_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rd_en = 1'b0;
            check(dout == last, "R9 empty read holds dout", dout, last);
            check(ptr == NW, "R9 empty read no pop", 36'(ptr), 36'(NW));
        end
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule